// File: doc/BRIEF.md
# Nine-Point Half-Pixel RGB565 Interpolator

This block forms one output pixel of a remapping engine whose coordinate table snaps each sample to a half-pixel grid. Each request carries up to four neighbouring 16-bit source pixels: the base pixel, its right neighbour, its lower neighbour and its lower-right (diagonal) neighbour. It also carries two flags that say whether the sample lies half a pixel to the right and/or half a pixel down. From these the block returns a direct copy, a two-pixel average or a four-pixel average. A request can also be marked void, for a table entry that points outside the source image. Such a request yields a black pixel. Averaging uses only adds and right shifts, and each colour field is handled separately.

Requests enter on a valid/ready stream and results leave on another. A request transfers on a clock edge where `in_valid` and `in_ready` are both high. A result transfers on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, the result is held unchanged and `in_ready` is low. The two pipeline stages then freeze together, so no request is lost, duplicated or reordered. `in_ready` does not depend on `in_valid`. When `out_ready` stays high the block accepts one request per clock.

Top module: `half_pel_blend`

## Requirements
- R1: With both half flags clear, the output equals the base pixel, and the right, lower and diagonal inputs have no effect.
- R2: With only the x-half flag set, each colour field of the output is floor((base + right) / 2), and the lower and diagonal inputs have no effect.
- R3: With only the y-half flag set, each colour field of the output is floor((base + lower) / 2), and the right and diagonal inputs have no effect.
- R4: With both half flags set, each colour field is floor((base + right + lower + diagonal) / 4).
- R5: Red is bits 15:11, green is bits 10:5 and blue is bits 4:0. The fields are averaged independently, with no carry or borrow between them, so all-ones inputs give all-ones outputs.
- R6: A request with the void flag set produces 16'h0000, whatever its pixels and flags.
- R7: With `out_ready` held high, the result of a request accepted in cycle N is presented with `out_valid` high in cycle N+2. Back-to-back requests produce back-to-back results.
- R8: While `out_valid` is high and `out_ready` is low, `out_pix` stays stable and `in_ready` is low. Results leave in request order, each exactly once.
- R9: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Block can take a request |
| in_base | input | 16 | Source pixel at (x, y) |
| in_right | input | 16 | Source pixel at (x+1, y) |
| in_down | input | 16 | Source pixel at (x, y+1) |
| in_diag | input | 16 | Source pixel at (x+1, y+1) |
| in_xhalf | input | 1 | Sample lies half a pixel right of the base |
| in_yhalf | input | 1 | Sample lies half a pixel below the base |
| in_void | input | 1 | Sample lies outside the source; output black |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer can take a result |
| out_pix | output | 16 | Result pixel, RGB565 |

## Verification
The bench builds the block with its default field widths of 5, 6 and 5 bits. Because the green field is one bit wider than the two fields beside it, a field-boundary error shows up as a wrong neighbour value. Extreme pixels (all ones, a single field saturated) reach the top of every sum and expose any carry leaking between fields. Small odd sums expose rounding where truncation is required. Back-pressure is exercised in two ways: a full stall that fills both stages, and a pseudo-random ready pattern over a long stream. Together these check the hold, ordering and ready-gating rules.

// File: rtl/hp_pkg.sv
package hp_pkg;

  // Divisor chosen by the snapped sample position.
  typedef enum logic [1:0] {
    HP_DIV1 = 2'd0,
    HP_DIV2 = 2'd1,
    HP_DIV4 = 2'd2
  } hp_div_e;

  function automatic hp_div_e hp_div(input logic xh, input logic yh);
    if (xh && yh)      return HP_DIV4;
    else if (xh || yh) return HP_DIV2;
    else               return HP_DIV1;
  endfunction

  // Channel 0 is blue (LSBs), 1 is green, 2 is red (MSBs).
  function automatic int hp_ch_w(input int i, input int rw, input int gw, input int bw);
    return (i == 0) ? bw : (i == 1) ? gw : rw;
  endfunction

  function automatic int hp_ch_lo(input int i, input int gw, input int bw);
    return (i == 0) ? 0 : (i == 1) ? bw : bw + gw;
  endfunction

endpackage

// File: rtl/hp_chan_sum.sv
module hp_chan_sum #(
  parameter int W = 5
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  input  logic [W-1:0] d,
  input  logic         xh,
  input  logic         yh,
  output logic [W+1:0] sum
);
  localparam int SW = W + 2;

  logic [SW-1:0] ea, eb, ec, ed;

  always_comb begin
    ea  = SW'(a);
    eb  = xh         ? SW'(b) : '0;
    ec  = yh         ? SW'(c) : '0;
    ed  = (xh && yh) ? SW'(d) : '0;
    sum = ea + eb + ec + ed;
  end
endmodule

// File: rtl/hp_chan_scale.sv
module hp_chan_scale
  import hp_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W+1:0] sum,
  input  hp_div_e      div,
  output logic [W-1:0] q
);
  always_comb begin
    unique case (div)
      HP_DIV2: q = sum[W:1];
      HP_DIV4: q = sum[W+1:2];
      default: q = sum[W-1:0];
    endcase
  end
endmodule

// File: rtl/hp_flow_ctl.sv
module hp_flow_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic adv,
  output logic in_ready,
  output logic s1_v,
  output logic out_valid
);
  // Both stages move together; they freeze only while a held result waits.
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v      <= 1'b0;
      out_valid <= 1'b0;
    end else if (adv) begin
      s1_v      <= in_valid;
      out_valid <= s1_v;
    end
  end
endmodule

// File: rtl/half_pel_blend.sv
module half_pel_blend
  import hp_pkg::*;
#(
  parameter int RED_W = 5,
  parameter int GRN_W = 6,
  parameter int BLU_W = 5
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           in_valid,
  output logic                           in_ready,
  input  logic [RED_W+GRN_W+BLU_W-1:0]   in_base,
  input  logic [RED_W+GRN_W+BLU_W-1:0]   in_right,
  input  logic [RED_W+GRN_W+BLU_W-1:0]   in_down,
  input  logic [RED_W+GRN_W+BLU_W-1:0]   in_diag,
  input  logic                           in_xhalf,
  input  logic                           in_yhalf,
  input  logic                           in_void,
  output logic                           out_valid,
  input  logic                           out_ready,
  output logic [RED_W+GRN_W+BLU_W-1:0]   out_pix
);
  localparam int PIX_W = RED_W + GRN_W + BLU_W;
  localparam int NCH   = 3;
  localparam int SUM_W = PIX_W + 2 * NCH;

  logic             adv;
  logic             s1_v;
  logic [SUM_W-1:0] sum_d;
  logic [SUM_W-1:0] s1_sum;
  hp_div_e          s1_div;
  logic             s1_void;
  logic [PIX_W-1:0] pix_d;

  hp_flow_ctl u_flow (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .adv       (adv),
    .in_ready  (in_ready),
    .s1_v      (s1_v),
    .out_valid (out_valid)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam int W   = hp_ch_w(i, RED_W, GRN_W, BLU_W);
    localparam int LO  = hp_ch_lo(i, GRN_W, BLU_W);
    localparam int SLO = LO + 2 * i;

    logic [W+1:0] sum_c;
    logic [W-1:0] q_c;

    hp_chan_sum #(.W(W)) u_sum (
      .a   (in_base[LO +: W]),
      .b   (in_right[LO +: W]),
      .c   (in_down[LO +: W]),
      .d   (in_diag[LO +: W]),
      .xh  (in_xhalf),
      .yh  (in_yhalf),
      .sum (sum_c)
    );
    assign sum_d[SLO +: W+2] = sum_c;

    hp_chan_scale #(.W(W)) u_scale (
      .sum (s1_sum[SLO +: W+2]),
      .div (s1_div),
      .q   (q_c)
    );
    assign pix_d[LO +: W] = q_c;
  end

  // Stage 1: widened per-field sums and the divisor.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_sum  <= '0;
      s1_div  <= HP_DIV1;
      s1_void <= 1'b0;
    end else if (adv) begin
      s1_sum  <= sum_d;
      s1_div  <= hp_div(in_xhalf, in_yhalf);
      s1_void <= in_void;
    end
  end

  // Stage 2: shift, pack, blank void samples.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_pix <= '0;
    end else if (adv) begin
      out_pix <= s1_void ? '0 : pix_d;
    end
  end
endmodule

// File: rtl/hp_chk.sv
module hp_chk #(
  parameter int PIX_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic [PIX_W-1:0] out_pix
);
  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_pix)));

  // R8
  ready_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R7
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && $past(in_valid && in_ready, 2) && $past(in_ready))
      |-> out_valid);

  // R7
  origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n, 2) && $past(rst_n) && out_valid && !$past(out_valid))
      |-> $past(in_valid && in_ready, 2));
endmodule

bind half_pel_blend hp_chk #(.PIX_W(PIX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_pix   (out_pix)
);

// File: tb/sim_half_pel_blend.sv
`timescale 1ns/1ps
module sim_half_pel_blend;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_ready;
  logic [15:0] in_base = '0, in_right = '0, in_down = '0, in_diag = '0;
  logic in_xhalf = 1'b0, in_yhalf = 1'b0, in_void = 1'b0;
  logic out_valid, out_ready;
  logic [15:0] out_pix;

  always #2.5 clk = ~clk;

  half_pel_blend u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_base(in_base), .in_right(in_right), .in_down(in_down), .in_diag(in_diag),
    .in_xhalf(in_xhalf), .in_yhalf(in_yhalf), .in_void(in_void),
    .out_valid(out_valid), .out_ready(out_ready), .out_pix(out_pix)
  );

  typedef struct {
    logic [15:0] pix;
    string       tag;
    int          acc;
    bit          lat;
  } exp_t;

  exp_t q[$];
  int checks = 0, fails = 0;
  int cyc = 0;
  int rdy_mode = 0;
  bit done = 0;
  logic [31:0] rng = 32'h1ACE_B00C;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] step(input logic [31:0] s);
    logic [31:0] t = s;
    t = t ^ (t << 13);
    t = t ^ (t >> 17);
    t = t ^ (t << 5);
    return t;
  endfunction

  // Reference built from the field layout and averaging rules.
  function automatic logic [15:0] model(input logic [15:0] a, b, c, d,
                                        input logic xh, yh, vd);
    int r, g, bl, n;
    if (vd) return 16'h0000;
    r  = a[15:11]; g = a[10:5]; bl = a[4:0];
    if (xh) begin r += b[15:11]; g += b[10:5]; bl += b[4:0]; end
    if (yh) begin r += c[15:11]; g += c[10:5]; bl += c[4:0]; end
    if (xh && yh) begin r += d[15:11]; g += d[10:5]; bl += d[4:0]; end
    n  = (xh ? 1 : 0) + (yh ? 1 : 0);
    r  = r >> n; g = g >> n; bl = bl >> n;
    return {r[4:0], g[5:0], bl[4:0]};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: present a request at the negedge, wait for acceptance, log expectation.
  task automatic send(input logic [15:0] a, b, c, d, input logic xh, yh, vd,
                      input string tag, input bit lat);
    exp_t e;
    in_valid = 1'b1;
    in_base = a; in_right = b; in_down = c; in_diag = d;
    in_xhalf = xh; in_yhalf = yh; in_void = vd;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    e.pix = model(a, b, c, d, xh, yh, vd);
    e.tag = tag;
    e.acc = cyc;
    e.lat = lat;
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  // Ready driver.
  initial begin
    out_ready = 1'b1;
    forever begin
      @(negedge clk);
      rng = step(rng);
      case (rdy_mode)
        1:       out_ready = rng[3];
        2:       out_ready = 1'b0;
        default: out_ready = 1'b1;
      endcase
    end
  end

  // Monitor / scoreboard.
  initial begin
    logic        held_v = 1'b0;
    logic [15:0] held_p = '0;
    exp_t e;
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        if (held_v && out_valid)
          check(out_pix == held_p, "R8 hold while stalled", out_pix, held_p);
        if (out_valid && !out_ready)
          check(!in_ready, "R8 in_ready low while stalled", {15'd0, in_ready}, 16'd0);
        if (out_valid && out_ready) begin
          if (q.size() == 0) begin
            check(1'b0, "R8 result with no request", out_pix, 16'h0);
          end else begin
            e = q.pop_front();
            check(out_pix == e.pix, e.tag, out_pix, e.pix);
            if (e.lat)
              check(cyc - e.acc == 2, "R7 latency", 16'(cyc - e.acc), 16'd2);
          end
        end
        held_v = out_valid && !out_ready;
        held_p = out_pix;
      end
    end
  end

  // Watchdog.
  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #2;
    // R9: reset state
    check(!out_valid, "R9 out_valid in reset", {15'd0, out_valid}, 16'd0);
    check(in_ready, "R9 in_ready in reset", {15'd0, in_ready}, 16'd1);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    check(!out_valid && in_ready, "R9 after reset", {14'd0, out_valid, in_ready}, 16'd1);
    @(negedge clk);

    // R1: copy, neighbours ignored
    send(16'h1234, 16'hFFFF, 16'hAAAA, 16'h5555, 0, 0, 0, "R1 copy", 1);
    send(16'hFFFF, 16'h0000, 16'h0000, 16'h0000, 0, 0, 0, "R1 copy max", 1);
    // R2: x-half, down/diag ignored
    send(16'hFFFF, 16'h0000, 16'hFFFF, 16'hFFFF, 1, 0, 0, "R2 x-half", 1);
    send(16'h0843, 16'h0821, 16'h0000, 16'h0000, 1, 0, 0, "R2 x-half trunc", 1);
    // R3: y-half, right/diag ignored
    send(16'hF800, 16'hFFFF, 16'h07FF, 16'hFFFF, 0, 1, 0, "R3 y-half", 1);
    send(16'h0001, 16'h0000, 16'h0000, 16'h1111, 0, 1, 0, "R3 y-half trunc", 1);
    // R4: quad
    send(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 1, 0, "R4 quad max", 1);
    send(16'h0861, 16'h0861, 16'h0861, 16'h0000, 1, 1, 0, "R4 quad trunc", 1);
    // R5: field isolation
    send(16'h001F, 16'h0001, 16'h0000, 16'h0000, 1, 0, 0, "R5 blue no carry", 1);
    send(16'h07E0, 16'h07E0, 16'h07E0, 16'h07E0, 1, 1, 0, "R5 green max", 1);
    send(16'hF81F, 16'h07E0, 16'h07E0, 16'hF81F, 1, 1, 0, "R5 mixed fields", 1);
    // R6: void
    send(16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 1, 1, 1, "R6 void quad", 1);
    send(16'h1234, 16'h5678, 16'h9ABC, 16'hDEF0, 0, 0, 1, "R6 void copy", 1);
    idle();
    repeat (4) @(negedge clk);

    // R7: back-to-back stream, full rate
    for (int i = 0; i < 40; i++) begin
      logic [31:0] s1, s2;
      rng = step(rng); s1 = rng;
      rng = step(rng); s2 = rng;
      send(s1[15:0], s1[31:16], s2[15:0], s2[31:16], s2[0], s2[1], s2[2] & s2[3],
           "R7 stream", 1);
    end
    idle();
    repeat (4) @(negedge clk);

    // R8: full stall then release
    fork
      begin
        for (int i = 0; i < 6; i++) begin
          logic [31:0] s1;
          rng = step(rng); s1 = rng;
          send(s1[15:0], ~s1[15:0], s1[31:16], ~s1[31:16], s1[4], s1[5], 0,
               "R8 stall order", 0);
        end
        idle();
      end
      begin
        rdy_mode = 2;
        repeat (10) @(negedge clk);
        rdy_mode = 0;
      end
    join
    repeat (6) @(negedge clk);

    // R8: random back-pressure
    rdy_mode = 1;
    for (int i = 0; i < 200; i++) begin
      logic [31:0] s1, s2;
      rng = step(rng); s1 = rng;
      rng = step(rng); s2 = rng;
      send(s1[15:0], s1[31:16], s2[15:0], s2[31:16], s2[7], s2[9], s2[11] & s2[12],
           "R8 random ready", 0);
    end
    idle();
    rdy_mode = 0;
    for (int i = 0; i < 200 && q.size() != 0; i++) @(negedge clk);
    check(q.size() == 0, "R8 all results delivered", 16'(q.size()), 16'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule